// File: doc/BRIEF.md
# VCO Sub-Band Search Controller

This block selects one of 64 coarse frequency bands for a voltage-controlled oscillator. A write to the synthesizer configuration register is presented to it as a one-cycle strobe. In automatic mode, with the search enable set, the strobe loads a programmed starting band. The block then moves one band at a time, guided by a 3-bit code from an ADC that watches the loop tuning voltage. It stops once the code shows the voltage is inside the acquisition window. In manual mode the programmed band is applied at once and no search runs.

After each band change the controller waits a programmable number of cycles for the loop to settle before it takes the next ADC sample. A programmable cycle budget bounds the whole search. The search ends with an error flag if it reaches the lowest or the highest band while the code still points further out. It ends with a timeout flag if the budget runs out, and in both cases it keeps the last band it applied. The band and the latest sampled code are outputs, so a register readback path can return them.

Top module: `vband_acq`

## Requirements
- R1: After reset, `band` is 31 (binary 011111), `busy`, `done`, `err_limit` and `timeout` are 0, and `last_code` is 000.
- R2: A `cfg_wr` pulse with `auto_mode`=0 loads `init_band` into `band` and sets `done` at the next clock edge, with no search and with `err_limit` and `timeout` cleared.
- R3: A `cfg_wr` pulse with `auto_mode`=1 and `srch_en`=1 loads `init_band`, clears all three status flags and raises `busy` at the next edge.
- R4: A sample taken during a search acts on the code as follows. Codes 000 and 001 (tuning voltage low) lower `band` by one. Codes 110 and 111 (voltage high) raise it by one. Codes 010 and 101 (inside the window) end the search with `done`=1 and the band unchanged.
- R5: Codes 011 and 100 have no meaning. A sample carrying one of them neither moves the band nor ends the search; the next valid sample is taken one cycle later.
- R6: After the band is loaded or stepped, `adc_valid` is ignored for `settle_cyc` cycles and sampled at the next edge. With `adc_valid` held high, successive steps are exactly `settle_cyc`+1 cycles apart.
- R7: A low code while `band` is 0, or a high code while `band` is 63, ends the search with `done` and `err_limit` set and the band held.
- R8: If the search has not ended, it stops at the `budget_cyc`-th clock edge after the trigger with `done` and `timeout` set and the band held at its last value.
- R9: A `cfg_wr` pulse with `auto_mode`=1 and `srch_en`=0 is ignored: band, flags and `busy` stay unchanged.
- R10: `last_code` holds the code of the most recent sample accepted after settling, including the unused codes.
- R11: A search that succeeds after n steps with no unused codes raises `done` (n+1)·(`settle_cyc`+1) cycles after the trigger edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | One-cycle strobe: synthesizer configuration register written |
| srch_en | input | 1 | Allows a configuration write to start a search |
| auto_mode | input | 1 | 1 = search from `init_band`, 0 = apply `init_band` directly |
| init_band | input | 6 | Programmed band (start point or manual value) |
| settle_cyc | input | 8 | Settling wait after each band change, in cycles |
| budget_cyc | input | 16 | Cycle budget for one search |
| adc_code | input | 3 | Tuning-voltage window code |
| adc_valid | input | 1 | `adc_code` carries a fresh conversion |
| band | output | 6 | Band applied to the oscillator |
| busy | output | 1 | Search in progress |
| done | output | 1 | Last operation finished (held until the next trigger) |
| err_limit | output | 1 | Search ended at a band limit |
| timeout | output | 1 | Search ended by the cycle budget |
| last_code | output | 3 | Most recent sampled ADC code |

## Verification
The bench builds the block with its default parameters: a 6-bit band, an 8-bit settle count, a 16-bit budget and the budget counter present. With a 6-bit band both limits are a few steps from realistic start points, so the error exits at band 0 and at band 63 are reached quickly. The 16-bit budget allows a small budget of 10 or 20 cycles, so a timeout can be forced both with the ADC silent and partway through a run of steps. The settle width covers a zero wait, where every cycle samples and the unused-code case can be timed exactly, as well as several nonzero waits.

// File: rtl/vband_pkg.sv
package vband_pkg;

   localparam int CODE_W = 3;

   typedef enum logic [1:0] {
      VC_LOW  = 2'd0,
      VC_IN   = 2'd1,
      VC_HIGH = 2'd2,
      VC_BAD  = 2'd3
   } vcls_e;

   function automatic vcls_e classify(input logic [CODE_W-1:0] c);
      case (c)
         3'b000, 3'b001: return VC_LOW;
         3'b010, 3'b101: return VC_IN;
         3'b110, 3'b111: return VC_HIGH;
         default:        return VC_BAD;
      endcase
   endfunction

endpackage

// File: rtl/vband_class.sv
module vband_class
   import vband_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   output vcls_e             cls_o
);
   always_comb cls_o = classify(code_i);
endmodule

// File: rtl/vband_down_cnt.sv
module vband_down_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic [W-1:0] cnt_o
);
   if (W < 1) begin : g_bad_w
      $error("vband_down_cnt: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_o <= '0;
      else if (load_i)               cnt_o <= load_val_i;
      else if (dec_i && cnt_o != '0) cnt_o <= cnt_o - 1'b1;
   end
endmodule

// File: rtl/vband_acq.sv
module vband_acq
   import vband_pkg::*;
#(
   parameter int BAND_W     = 6,
   parameter int SETTLE_W   = 8,
   parameter int BUDGET_W   = 16,
   parameter bit USE_BUDGET = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic                srch_en,
   input  logic                auto_mode,
   input  logic [BAND_W-1:0]   init_band,
   input  logic [SETTLE_W-1:0] settle_cyc,
   input  logic [BUDGET_W-1:0] budget_cyc,
   input  logic [CODE_W-1:0]   adc_code,
   input  logic                adc_valid,
   output logic [BAND_W-1:0]   band,
   output logic                busy,
   output logic                done,
   output logic                err_limit,
   output logic                timeout,
   output logic [CODE_W-1:0]   last_code
);
   localparam logic [BAND_W-1:0] BAND_MAX = {BAND_W{1'b1}};
   localparam logic [BAND_W-1:0] BAND_DEF = BAND_MAX >> 1;

   if (BAND_W < 2 || BAND_W > 10) begin : g_bad_band
      $error("vband_acq: BAND_W outside 2..10");
   end
   if (SETTLE_W < 1) begin : g_bad_settle
      $error("vband_acq: SETTLE_W must be at least 1");
   end
   if (BUDGET_W < 2) begin : g_bad_budget
      $error("vband_acq: BUDGET_W must be at least 2");
   end

   // ---------------- trigger decode ----------------
   logic start_man, start_auto;
   assign start_man  = cfg_wr && !auto_mode;
   assign start_auto = cfg_wr && auto_mode && srch_en;

   // ---------------- code classification ----------------
   vcls_e cls;
   vband_class u_class (.code_i(adc_code), .cls_o(cls));

   // ---------------- settle counter ----------------
   logic [SETTLE_W-1:0] set_cnt;
   logic                settled, smp, take, go_dn, go_up, at_lim, step;
   logic                bud_last;

   assign settled = (set_cnt == '0);
   assign smp     = busy && settled && adc_valid;
   assign take    = smp && (cls != VC_BAD);
   assign go_dn   = take && (cls == VC_LOW);
   assign go_up   = take && (cls == VC_HIGH);
   assign at_lim  = (go_dn && band == '0) || (go_up && band == BAND_MAX);
   assign step    = (go_dn || go_up) && !at_lim && !bud_last;

   vband_down_cnt #(.W(SETTLE_W)) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (start_auto || (!cfg_wr && step)),
      .load_val_i(settle_cyc),
      .dec_i     (busy),
      .cnt_o     (set_cnt)
   );

   // ---------------- budget counter ----------------
   if (USE_BUDGET) begin : g_budget
      logic [BUDGET_W-1:0] bud_cnt;
      vband_down_cnt #(.W(BUDGET_W)) u_budget (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_i    (start_auto),
         .load_val_i(budget_cyc),
         .dec_i     (busy),
         .cnt_o     (bud_cnt)
      );
      assign bud_last = busy && (bud_cnt <= BUDGET_W'(1));
   end else begin : g_no_budget
      assign bud_last = 1'b0;
   end

   // ---------------- control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         band      <= BAND_DEF;
         busy      <= 1'b0;
         done      <= 1'b0;
         err_limit <= 1'b0;
         timeout   <= 1'b0;
      end else if (start_man) begin
         band      <= init_band;
         busy      <= 1'b0;
         done      <= 1'b1;
         err_limit <= 1'b0;
         timeout   <= 1'b0;
      end else if (start_auto) begin
         band      <= init_band;
         busy      <= 1'b1;
         done      <= 1'b0;
         err_limit <= 1'b0;
         timeout   <= 1'b0;
      end else if (busy) begin
         if (take && cls == VC_IN) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else if (at_lim) begin
            busy      <= 1'b0;
            done      <= 1'b1;
            err_limit <= 1'b1;
         end else if (bud_last) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            timeout <= 1'b1;
         end else if (go_dn) begin
            band <= band - 1'b1;
         end else if (go_up) begin
            band <= band + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 last_code <= '0;
      else if (smp && !cfg_wr)    last_code <= adc_code;
   end

   // ---------------- assertions ----------------
   // R6
   settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !settled && !cfg_wr |=> $stable(band));

   // R4
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !cfg_wr |=> (band == $past(band)) || (band == $past(band) + 1'b1)
                          || (band == $past(band) - 1'b1));

   // R7
   limit_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_limit) |-> (band == '0) || (band == BAND_MAX));

   // R8
   timeout_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> done && !busy && $stable(band));

   // R2
   manual_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_man |=> band == $past(init_band) && done && !busy);

   // R9
   no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && auto_mode && !srch_en && !busy |=> $stable(band) && $stable(done) && !busy);

   // R10
   code_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp && !cfg_wr |=> last_code == $past(adc_code));

   // R5
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp && cls == VC_BAD && !cfg_wr |=> $stable(band) && busy);

endmodule

// File: tb/tb_vband_acq.sv
module tb_vband_acq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0, srch_en = 1'b0, auto_mode = 1'b0;
   logic [5:0] init_band = '0;
   logic [7:0] settle_cyc = '0;
   logic [15:0] budget_cyc = 16'd1000;
   logic [2:0] adc_code = '0;
   logic       adc_valid = 1'b0;
   logic [5:0] band;
   logic       busy, done, err_limit, timeout;
   logic [2:0] last_code;

   always #5 clk = ~clk;

   vband_acq dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .srch_en(srch_en),
      .auto_mode(auto_mode), .init_band(init_band), .settle_cyc(settle_cyc),
      .budget_cyc(budget_cyc), .adc_code(adc_code), .adc_valid(adc_valid),
      .band(band), .busy(busy), .done(done), .err_limit(err_limit),
      .timeout(timeout), .last_code(last_code)
   );

   int n_chk = 0, n_fail = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- ADC model ----------------
   int         tgt = 100;
   int         junk_n = 0;
   logic       adc_on = 1'b0;
   logic [2:0] in_code = 3'b010;
   int         eq_seen = 0;

   always @(negedge clk) begin
      int b;
      b = int'(band);
      adc_valid <= adc_on;
      if (b > tgt) begin
         adc_code <= (b == tgt + 1) ? 3'b001 : 3'b000;
         eq_seen  <= 0;
      end else if (b < tgt) begin
         adc_code <= (b == tgt - 1) ? 3'b110 : 3'b111;
         eq_seen  <= 0;
      end else if (eq_seen < junk_n) begin
         adc_code <= eq_seen[0] ? 3'b100 : 3'b011;
         eq_seen  <= eq_seen + 1;
      end else begin
         adc_code <= in_code;
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      int  band;
      bit  err;
      bit  tmo;
      int  code;
      int  lat;
      string req;
   } exp_t;
   exp_t q[$];

   int cyc = 0, trig_cyc = 0, last_chg = 0, cur_s = 0;
   logic done_prev = 1'b0, busy_prev = 1'b0;
   logic [5:0] band_prev = '0;

   initial begin
      forever begin
         @(posedge clk);
         #2;
         cyc++;
         if (rst_n) begin
            if (cfg_wr && (!auto_mode || srch_en)) begin
               trig_cyc = cyc;
               last_chg = cyc;
               cur_s    = int'(settle_cyc);
            end else if (busy_prev && band != band_prev) begin
               // R6: step spacing with valid held high
               chk("R6", "step spacing", cyc - last_chg, cur_s + 1);
               last_chg = cyc;
            end
            if (done && (!done_prev || (cfg_wr && !auto_mode))) begin
               if (q.size() == 0) begin
                  chk("R4", "unexpected completion", 1, 0);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  chk(e.req, "band", int'(band), e.band);
                  chk("R7", "err_limit", int'(err_limit), int'(e.err));
                  chk("R8", "timeout", int'(timeout), int'(e.tmo));
                  chk("R10", "last_code", int'(last_code), e.code);
                  chk("R11", "latency", cyc - trig_cyc, e.lat);
                  chk("R3", "busy cleared", int'(busy), 0);
               end
            end
         end
         done_prev = done;
         busy_prev = busy;
         band_prev = band;
      end
   end

   // ---------------- driver ----------------
   task automatic run(input bit amode, input int ib, input int t, input int s, input int bud,
                      input logic [2:0] inc, input int jn, input bit on,
                      input int eb, input bit ee, input bit et, input int ec, input int el,
                      input string req);
      exp_t e;
      @(negedge clk);
      tgt = t; junk_n = jn; in_code = inc; adc_on = on;
      auto_mode = amode; srch_en = 1'b1;
      init_band = 6'(ib); settle_cyc = 8'(s); budget_cyc = 16'(bud);
      e.band = eb; e.err = ee; e.tmo = et; e.code = ec; e.lat = el; e.req = req;
      q.push_back(e);
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (amode) chk("R3", "busy after trigger", int'(busy), 1);
      while (q.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "band", int'(band), 31);
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "done", int'(done), 0);
      chk("R1", "flags", int'(err_limit) + int'(timeout), 0);
      chk("R1", "last_code", int'(last_code), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4 upward search: 5 steps, settle 3 -> 6*4 cycles
      run(1, 31, 36, 3, 1000, 3'b010, 0, 1, 36, 0, 0, 3'b010, 24, "R4");
      // R4 downward search with code 101 ending it: 8 steps, settle 2
      run(1, 20, 12, 2, 1000, 3'b101, 0, 1, 12, 0, 0, 3'b101, 27, "R4");
      // R11 already in window: one sample after settle 5
      run(1, 40, 40, 5, 1000, 3'b010, 0, 1, 40, 0, 0, 3'b010, 6, "R11");
      // R7 lower limit
      run(1, 3, -5, 1, 1000, 3'b010, 0, 1, 0, 1, 0, 3'b000, 8, "R7");
      // R7 upper limit
      run(1, 60, 70, 0, 1000, 3'b010, 0, 1, 63, 1, 0, 3'b111, 4, "R7");
      // R5 unused codes at the target band: three extra samples
      run(1, 10, 13, 0, 1000, 3'b010, 3, 1, 13, 0, 0, 3'b010, 7, "R5");
      // R8 timeout with ADC silent
      run(1, 25, 25, 2, 20, 3'b010, 0, 0, 25, 0, 1, 3'b010, 20, "R8");
      // R8 timeout partway through stepping: band held at 2
      run(1, 0, 60, 3, 10, 3'b010, 0, 1, 2, 0, 1, 3'b111, 10, "R8");
      // R2 manual load
      run(0, 7, 100, 0, 1000, 3'b010, 0, 1, 7, 0, 0, 3'b111, 0, "R2");

      // R9 ignored trigger in auto mode with enable low
      @(negedge clk);
      auto_mode = 1'b1; srch_en = 1'b0; init_band = 6'd50; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9", "band unchanged", int'(band), 7);
      chk("R9", "done unchanged", int'(done), 1);
      chk("R9", "busy stays low", int'(busy), 0);
      chk("R9", "no completion queued", q.size(), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule